// File: doc/BRIEF.md
# Audio Clock Monitor with Sticky Change Errors

The monitor watches three audio clocks on a system-clock domain: a master clock, a bit clock and a frame clock. All three are sampled as plain inputs. Every frame-clock rising edge closes a measurement window. In each window the block counts system-clock cycles, master-clock rising edges and bit-clock rising edges. A count locks once two consecutive windows agree. After it has locked, any window that disagrees with the locked value marks that clock as unsteady.

The locked frame period is sorted into a sample-rate family by checking it against three tolerance windows. The locked master-clock and bit-clock counts are decoded into ratio codes. These codes form a read-only status byte. Each unsteady condition feeds a sticky error bit. Software clears an error bit by writing zero to it. The bit sets again on the following cycle if the clock is still unsteady, so a later read tells a passing glitch from a lasting fault. A simple register port gives access to the status byte and the error byte.

Top module: `aud_clk_monitor`

## Requirements
- R1: The master-clock error (error byte bit 2) is set when the count of master-clock rising edges per frame differs from its locked value.
- R2: The bit-clock error (error byte bit 1) is set when the count of bit-clock rising edges per frame differs from its locked value.
- R3: The frame error (error byte bit 0) is set when the frame period, counted in system-clock cycles, differs from its locked value.
- R4: Error bits are sticky. Hardware never clears them. A write to the error address clears each bit written as 0 and leaves each bit written as 1 unchanged. Bits 7 to 3 read 0.
- R5: While a clock remains unsteady, its error bit is set again on the cycle after a clearing write. When a clearing write and a set fall in the same cycle, the set wins.
- R6: Status bits 7:5 give the rate family of the locked frame period: 3'b001 for the 32 kHz family, 3'b010 for the 44.1 kHz family, 3'b011 for the 48 kHz family. They read 3'b000 when the period is unlocked or outside every window. A window is nominal ± (nominal >> TOL_SHIFT).
- R7: Status bits 4:2 give the master-clock ratio code: 1, 2, 3, 4, 5 and 6 for 64, 128, 192, 256, 384 and 512 clocks per frame. They read 0 for any other count or while unlocked.
- R8: Status bits 1:0 give the bit-clock ratio code: 2'b01 for 32, 2'b10 for 48 and 2'b11 for 64 per frame. They read 0 for any other count or while unlocked.
- R9: A count locks only after two consecutive full frames agree. A change is declared only against a locked value, so the partial first window after reset and the frames of an alternating count raise no new error.
- R10: Address 0 reads the status byte and ignores writes. Address 1 reads and clears the error byte. After reset, both bytes read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_i | input | 1 | Master clock, sampled |
| sclk_i | input | 1 | Bit clock, sampled |
| lrclk_i | input | 1 | Frame clock, sampled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = error byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |

## Verification
The two functions that can collide are a clearing write from software and a hardware set from a clock that is still unsteady. Both can act on the same error bit in the same cycle. The bench provokes this by making the master clock alternate between two rates on successive frames, so its count never locks again. It then writes zeros to the error byte. It judges the result by reading the error byte right after the write: bit 2 must still read 1, and the master-clock status field must read 0. Once the clock is steady again, the same write must read back 0.

// File: rtl/acm_pkg.sv
`timescale 1ns/1ps
// Shared codes and decode functions for the audio clock monitor.
// Assumes counts are zero-extended to 32 bits by the caller.
package acm_pkg;
    localparam int N_TRK = 3;             // 0 frame period, 1 bit clock, 2 master clock
    localparam int IDX_FRM = 0;
    localparam int IDX_SCK = 1;
    localparam int IDX_MCK = 2;

    typedef enum logic [2:0] {
        RATE_NONE = 3'd0,
        RATE_F32  = 3'd1,
        RATE_F44  = 3'd2,
        RATE_F48  = 3'd3
    } rate_e;

    // True when per lies within nom +/- (nom >> sh)
    function automatic logic in_window(input logic [31:0] per, input logic [31:0] nom,
                                       input logic [4:0] sh);
        logic [31:0] tol;
        tol = nom >> sh;
        return (per >= nom - tol) && (per <= nom + tol);
    endfunction

    // Rate family of a frame period; the 48 kHz window is tried first
    function automatic rate_e rate_class(input logic [31:0] per, input logic [31:0] n32,
                                         input logic [31:0] n44, input logic [31:0] n48,
                                         input logic [4:0] sh);
        if (in_window(per, n48, sh)) return RATE_F48;
        if (in_window(per, n44, sh)) return RATE_F44;
        if (in_window(per, n32, sh)) return RATE_F32;
        return RATE_NONE;
    endfunction

    // Master clocks per frame to a 3-bit ratio code
    function automatic logic [2:0] mck_code(input logic [31:0] n);
        case (n)
            32'd64:  return 3'd1;
            32'd128: return 3'd2;
            32'd192: return 3'd3;
            32'd256: return 3'd4;
            32'd384: return 3'd5;
            32'd512: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    // Bit clocks per frame to a 2-bit ratio code
    function automatic logic [1:0] sck_code(input logic [31:0] n);
        case (n)
            32'd32:  return 2'd1;
            32'd48:  return 2'd2;
            32'd64:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/acm_edge_sync.sv
`timescale 1ns/1ps
// Brings one asynchronous clock line into the system domain and flags its
// rising edges. Assumes the line stays high and low for at least one system
// clock each, so no edge is lost.
module acm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o
);
    logic [2:0] pipe_q;

    // Two synchroniser stages plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= 3'b000;
        else        pipe_q <= {pipe_q[1:0], line_i};
    end

    assign rise_o = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/acm_ratio_track.sv
`timescale 1ns/1ps
// Counts events between frame strobes and tracks whether the per-frame count
// is steady. The count locks after two consecutive full frames agree. A
// mismatch against the locked value unlocks it and raises unsteady_o, which
// stays high until the count locks again. The first window after reset is
// partial and is only recorded. The accumulator saturates.
module acm_ratio_track #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o,
    output logic             locked_o,
    output logic             unsteady_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] acc_q, last_q;
    logic             seen_q, locked_q, unst_q;

    // Accumulate events; at each strobe compare with the previous window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            last_q   <= '0;
            seen_q   <= 1'b0;
            locked_q <= 1'b0;
            unst_q   <= 1'b0;
        end else if (frame_stb) begin
            acc_q  <= inc ? CNT_MAX'(1) : '0;
            last_q <= acc_q;
            seen_q <= 1'b1;
            if (seen_q) begin
                if (locked_q && (acc_q != last_q)) begin
                    locked_q <= 1'b0;
                    unst_q   <= 1'b1;
                end else if (!locked_q && (acc_q == last_q)) begin
                    locked_q <= 1'b1;
                    unst_q   <= 1'b0;
                end
            end
        end else if (inc && (acc_q != CNT_MAX)) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    assign count_o    = last_q;
    assign locked_o   = locked_q;
    assign unsteady_o = unst_q;
endmodule

// File: rtl/aud_clk_monitor.sv
`timescale 1ns/1ps
// Audio clock monitor. Measures the frame period in system clocks and the
// master and bit clocks per frame. Publishes the rate family and ratio codes
// in a read-only status byte and keeps sticky change errors that software
// clears by writing zeros. Assumes every audio clock is slower than half the
// system clock.
module aud_clk_monitor #(
    parameter int PER_W     = 16,
    parameter int CNT_W     = 12,
    parameter int NOM32_CYC = 6250,
    parameter int NOM44_CYC = 4535,
    parameter int NOM48_CYC = 4167,
    parameter int TOL_SHIFT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_i,
    input  logic       sclk_i,
    input  logic       lrclk_i,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    import acm_pkg::*;

    localparam int ERR_W = N_TRK;

    logic [N_TRK-1:0] rise_w, lock_w, unst_w;
    logic [N_TRK-1:0] line_w;
    logic [PER_W-1:0] per_cnt;
    logic [CNT_W-1:0] sck_cnt, mck_cnt;
    logic [7:0]       status_d, status_q;
    logic [ERR_W-1:0] err_q;
    logic             frame_stb;
    logic             unused_wbits;

    assign line_w = {mclk_i, sclk_i, lrclk_i};

    // One synchroniser and edge detector per watched clock
    for (genvar g = 0; g < N_TRK; g++) begin : g_sync
        acm_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_w[g]),
            .rise_o(rise_w[g])
        );
    end

    assign frame_stb = rise_w[IDX_FRM];

    acm_ratio_track #(.CNT_W(PER_W)) u_trk_per (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .inc(1'b1),
        .count_o(per_cnt), .locked_o(lock_w[IDX_FRM]), .unsteady_o(unst_w[IDX_FRM])
    );

    acm_ratio_track #(.CNT_W(CNT_W)) u_trk_sck (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .inc(rise_w[IDX_SCK]),
        .count_o(sck_cnt), .locked_o(lock_w[IDX_SCK]), .unsteady_o(unst_w[IDX_SCK])
    );

    acm_ratio_track #(.CNT_W(CNT_W)) u_trk_mck (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .inc(rise_w[IDX_MCK]),
        .count_o(mck_cnt), .locked_o(lock_w[IDX_MCK]), .unsteady_o(unst_w[IDX_MCK])
    );

    // Decode locked counts into the status fields
    always_comb begin
        status_d = 8'h00;
        if (lock_w[IDX_FRM])
            status_d[7:5] = rate_class(32'(per_cnt), 32'(NOM32_CYC), 32'(NOM44_CYC),
                                       32'(NOM48_CYC), 5'(TOL_SHIFT));
        if (lock_w[IDX_MCK]) status_d[4:2] = mck_code(32'(mck_cnt));
        if (lock_w[IDX_SCK]) status_d[1:0] = sck_code(32'(sck_cnt));
    end

    // Status register and sticky errors; a hardware set wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 8'h00;
            err_q    <= '0;
        end else begin
            status_q <= status_d;
            err_q    <= ((reg_wr && reg_addr) ? (err_q & reg_wdata[ERR_W-1:0]) : err_q)
                        | unst_w;
        end
    end

    assign unused_wbits = ^reg_wdata[7:ERR_W];

    // Read multiplexer
    assign reg_rdata = reg_addr ? {{(8-ERR_W){1'b0}}, err_q} : status_q;
endmodule

// File: rtl/aud_clk_monitor_chk.sv
`timescale 1ns/1ps
// Property checker for the audio clock monitor, attached by bind.
module aud_clk_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [2:0] err_q,
    input logic [7:0] status_q,
    input logic [2:0] lock_w,
    input logic [2:0] unst_w
);
    for (genvar i = 0; i < 3; i++) begin : g_bit
        AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[i] && !(reg_wr && reg_addr && !reg_wdata[i])) |=> err_q[i]); // R4
        AST_UNSTEADY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            unst_w[i] |=> err_q[i]); // R5
        AST_CHANGE_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(unst_w[i]) |-> $past(lock_w[i])); // R9
    end
    AST_MCK_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        unst_w[2] |=> (status_q[4:2] == 3'd0)); // R1
    AST_RATE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[7:5] != 3'd0) |-> $past(lock_w[0])); // R6
    AST_MCK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[4:2] != 3'd0) |-> $past(lock_w[2])); // R7
    AST_SCK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[1:0] != 2'd0) |-> $past(lock_w[1])); // R8
endmodule

bind aud_clk_monitor aud_clk_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .err_q    (err_q),
    .status_q (status_q),
    .lock_w   (lock_w),
    .unst_w   (unst_w)
);

// File: tb/aud_clk_monitor_bench.sv
`timescale 1ns/1ps
// Bench: generates the three audio clocks from a tick counter, so each
// per-frame count is an exact quotient, and sweeps rate, ratio and jitter
// settings of a reduced configuration.
module aud_clk_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0, sclk = 1'b0, lrclk = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int  n_vec = 0, n_bad = 0;
    bit  done = 1'b0;
    bit  run = 1'b0;
    bit  jit = 1'b0;
    int  hl = 256, hm = 2, hs = 4;
    int  t = 0;

    always #2.5 clk = ~clk;

    aud_clk_monitor #(
        .PER_W(16), .CNT_W(12),
        .NOM32_CYC(768), .NOM44_CYC(557), .NOM48_CYC(512), .TOL_SHIFT(5)
    ) u_aud_clk_monitor (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .sclk_i(sclk), .lrclk_i(lrclk),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Clock generator; jitter alternates the master half-period per frame
    always @(posedge clk) begin
        if (run) begin
            int hme;
            hme = (jit && (((t + hl) / (2 * hl)) % 2 == 1)) ? 2 : hm;
            t     <= t + 1;
            lrclk <= ((t / hl) % 2) == 1;
            sclk  <= ((t / hs) % 2) == 1;
            mclk  <= ((t / hme) % 2) == 1;
        end
    end

    task automatic rd(input bit a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_vec++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic frames(input int n);
        repeat (n * 2 * hl) @(posedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(1'b0, 8'h00, "R10 status after reset");
        rd(1'b1, 8'h00, "R10 errors after reset");
        run = 1'b1;
        frames(6);
        rd(1'b0, 8'h6B, "R6 R7 R8 48k fam, mclk 128, sclk 64");
        rd(1'b1, 8'h00, "R9 partial first window raises nothing");
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h6B, "R10 status ignores writes");
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'h00, "R4 writing ones sets nothing");
        // R1: master clock ratio change
        hm = 1; frames(6);
        rd(1'b0, 8'h73, "R7 mclk 256");
        rd(1'b1, 8'h04, "R1 mclk change flagged alone");
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'h04, "R4 writing ones keeps the bit");
        wr(1'b1, 8'hFB);
        rd(1'b1, 8'h00, "R4 writing zero clears");
        // R2: bit clock ratio change
        hs = 8; frames(6);
        rd(1'b0, 8'h71, "R8 sclk 32");
        rd(1'b1, 8'h02, "R2 sclk change flagged alone");
        wr(1'b1, 8'h00);
        // R5: persistent fault collides with clearing write
        jit = 1'b1; frames(6);
        rd(1'b0, 8'h61, "R9 alternating mclk stays unlocked");
        rd(1'b1, 8'h04, "R1 mclk unsteady");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h04, "R5 set wins over clear while unsteady");
        jit = 1'b0; frames(6);
        rd(1'b0, 8'h71, "R7 mclk relocked");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R5 clear holds once steady");
        // R3: frame period change into the 32k family
        hl = 384; frames(6);
        rd(1'b0, 8'h36, "R6 R7 R8 32k fam, mclk 384, sclk 48");
        rd(1'b1, 8'h07, "R3 frame change flags all three");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R4 clear after 32k lock");
        // 44.1k family with non-standard ratios
        hl = 280; frames(6);
        rd(1'b0, 8'h40, "R6 44.1k fam, R7 R8 unknown ratios read 0");
        rd(1'b1, 8'h07, "R3 second frame change");
        wr(1'b1, 8'h00);
        // Period outside every window
        hl = 320; frames(6);
        rd(1'b0, 8'h00, "R6 out-of-window period reads 0");
        rd(1'b1, 8'h07, "R3 third frame change");
        done = 1'b1;
        summary();
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule